// File: doc/BRIEF.md
# System Peripheral Space Address Router

The router sits between a processor's load/store path and the registers of its private 1 MB system peripheral window at 0xE0000000. Each request carries an address, a byte count, a read/write flag, write data, a secure attribute and an unprivileged (user) attribute. In the same cycle the router decodes the address and strobes at most one of four downstream register ports: the system-register/interrupt-controller block, a non-secure tick timer, a secure tick timer and an error-record block. One cycle later it returns a registered response with read data and an error flag.

Decode is done by region priority. A catch-all default region spans the whole window at the lowest priority. The system-register page sits above it, and the tick-timer slice, which is nested inside that page, sits above both. Addresses that no region claims are handled by the router itself: privileged accesses read zero and writes are dropped, while user accesses fault. When the security extension is built in, a second page serves as a non-secure view of the system-register page. A secure access there is forwarded to the real page with its secure attribute cleared. Non-secure accesses there are treated like unclaimed space.

Top module: `ppb_router`

## Requirements
- R1: A request whose address lies outside 0xE0000000..0xE00FFFFF strobes no downstream port and is answered with rsp_err=1 and rsp_rdata=0.
- R2: A request whose req_size (byte count) is 0 or greater than 8 strobes no port and is answered with rsp_err=1; sizes 1 to 8 are legal.
- R3: An in-window, legal-size request that no region claims strobes no port; if req_user=0 it returns rsp_err=0 and rsp_rdata=0 (writes have no effect), and if req_user=1 it returns rsp_err=1.
- R4: Addresses 0xE000E000..0xE000EFFF outside the tick slice strobe the system-register port (index 0), with tgt_addr = address bits [11:0] and tgt_secure = req_secure.
- R5: Addresses 0xE000E010..0xE000E0EF take priority over the system-register page and strobe a tick-timer port, with tgt_addr = address minus 0xE000E010.
- R6: A tick-timer access with req_secure=1 goes to the secure tick port (index 2), and one with req_secure=0 goes to the non-secure tick port (index 1).
- R7: With SEC_EN=1, a secure access to 0xE002E000..0xE002EFFF is forwarded exactly as the same offset in the 0xE000E000 page would be, but with tgt_secure=0. The tick slice of the alias therefore goes to the non-secure tick port.
- R8: With SEC_EN=1, a non-secure access to the alias page strobes no port; a privileged one reads zero with rsp_err=0, and a user one returns rsp_err=1.
- R9: With ERR_EN=1, addresses 0xE0005000..0xE0005FFF strobe the error-record port (index 3), with tgt_addr = address bits [11:0].
- R10: rsp_valid follows req_valid by exactly one clock. For a forwarded request, rsp_err equals the selected port's tgt_err. rsp_rdata equals that port's data for a read without error, and is zero for writes and for any error.
- R11: With SEC_EN=0, the alias page behaves as unclaimed space and every tick access goes to the non-secure port. With ERR_EN=0, the error-record page behaves as unclaimed space.
- R12: At most one downstream port is strobed per cycle, and none while req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| req_user | input | 1 | Unprivileged attribute of the request |
| tgt_valid | output | NUM_TGT | One-hot strobe: 0 system regs, 1 tick NS, 2 tick S, 3 error record |
| tgt_addr | output | PAGE_AW | Offset within the selected target |
| tgt_size | output | 4 | Forwarded byte count |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_secure | output | 1 | Security attribute seen by the target |
| tgt_user | output | 1 | Forwarded unprivileged attribute |
| tgt_rdata | input | NUM_TGT*DW | Read data of each target, port k in slice k |
| tgt_err | input | NUM_TGT | Error flag of each target |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW | Response read data |
| rsp_err | output | 1 | Response error flag |

## Verification
A wrong region pick or a wrong priority becomes visible in the same cycle as a strobe on the wrong downstream port, or as a missing strobe, together with an offset or secure attribute that does not match. One cycle later it also shows as response data tagged with the wrong target or as a flipped error flag. The stimulus is aimed at the edges of the nested tick slice, at both security states on the alias page, at illegal sizes and at addresses just outside the window. A second instance built without the security extension and without the error-record block shows whether those pages fall back to the default handling.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int NUM_TGT = 4;
  localparam logic [1:0] TGT_SYS     = 2'd0;
  localparam logic [1:0] TGT_TICK_NS = 2'd1;
  localparam logic [1:0] TGT_TICK_S  = 2'd2;
  localparam logic [1:0] TGT_ERREC   = 2'd3;

  localparam int NUM_RGN = 6;
  typedef enum logic [2:0] {
    RG_DFLT  = 3'd0,
    RG_SYS   = 3'd1,
    RG_TICK  = 3'd2,
    RG_ERREC = 3'd3,
    RG_ASYS  = 3'd4,
    RG_ATICK = 3'd5
  } rgn_e;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_RAZ   = 2'd1,
    ACT_FAULT = 2'd2
  } act_e;

  typedef struct packed {
    act_e        act;
    logic [1:0]  tgt;
    logic [11:0] off;
    logic        sec;
  } route_t;

  // Overlap priority: the larger number wins.
  function automatic int rgn_prio(int r);
    case (r)
      0:       return -1;
      1, 4:    return 0;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/ppb_region_hit.sv
module ppb_region_hit
  import ppb_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          WIN_AW    = 20,
  parameter int          PAGE_AW   = 12,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000,
  parameter int          SYS_PAGE  = 'h0E,
  parameter int          ALIAS_PG  = 'h2E,
  parameter int          EREC_PAGE = 'h05,
  parameter int          TICK_LO   = 'h010,
  parameter int          TICK_LEN  = 'h0E0,
  parameter bit          SEC_EN    = 1'b1,
  parameter bit          ERR_EN    = 1'b1
) (
  input  logic [AW-1:0]      addr,
  output logic [NUM_RGN-1:0] hit
);
  localparam int PG_W = WIN_AW - PAGE_AW;
  localparam logic [PAGE_AW-1:0] T_LO = PAGE_AW'(TICK_LO);
  localparam logic [PAGE_AW-1:0] T_HI = PAGE_AW'(TICK_LO + TICK_LEN);

  logic            in_win;
  logic [PG_W-1:0] page;
  logic [PAGE_AW-1:0] low;
  logic            in_tick;
  logic            pg_sys, pg_alias, pg_erec;

  always_comb begin
    in_win   = (addr[AW-1:WIN_AW] == WIN_BASE[AW-1:WIN_AW]);
    page     = addr[WIN_AW-1:PAGE_AW];
    low      = addr[PAGE_AW-1:0];
    in_tick  = (low >= T_LO) && (low < T_HI);
    pg_sys   = in_win && (page == PG_W'(SYS_PAGE));
    pg_alias = in_win && (page == PG_W'(ALIAS_PG)) && SEC_EN;
    pg_erec  = in_win && (page == PG_W'(EREC_PAGE)) && ERR_EN;
    hit             = '0;
    hit[RG_DFLT]    = in_win;
    hit[RG_SYS]     = pg_sys;
    hit[RG_TICK]    = pg_sys && in_tick;
    hit[RG_ERREC]   = pg_erec;
    hit[RG_ASYS]    = pg_alias;
    hit[RG_ATICK]   = pg_alias && in_tick;
  end
endmodule

// File: rtl/ppb_prio_pick.sv
module ppb_prio_pick
  import ppb_pkg::*;
#(
  parameter int NR = NUM_RGN
) (
  input  logic [NR-1:0] hit,
  output rgn_e          sel,
  output logic          any
);
  int best;
  always_comb begin
    sel  = RG_DFLT;
    any  = 1'b0;
    best = -2;
    for (int r = 0; r < NR; r++) begin
      if (hit[r] && (rgn_prio(r) > best)) begin
        best = rgn_prio(r);
        sel  = rgn_e'(3'(r));
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppb_route.sv
module ppb_route
  import ppb_pkg::*;
#(
  parameter int PAGE_AW  = 12,
  parameter int TICK_LO  = 'h010,
  parameter bit SEC_EN   = 1'b1
) (
  input  logic               any,
  input  rgn_e               sel,
  input  logic [3:0]         size,
  input  logic               secure,
  input  logic               user,
  input  logic [PAGE_AW-1:0] low,
  output route_t             rt
);
  localparam logic [PAGE_AW-1:0] T_LO = PAGE_AW'(TICK_LO);

  logic size_ok;
  logic unclaimed;

  always_comb begin
    size_ok   = (size != 4'd0) && (size <= 4'd8);
    unclaimed = 1'b0;
    rt        = '{act: ACT_FAULT, tgt: TGT_SYS, off: '0, sec: 1'b0};
    if (any && size_ok) begin
      case (sel)
        RG_SYS: begin
          rt = '{act: ACT_FWD, tgt: TGT_SYS, off: 12'(low), sec: secure};
        end
        RG_TICK: begin
          rt = '{act: ACT_FWD, tgt: (SEC_EN && secure) ? TGT_TICK_S : TGT_TICK_NS,
                 off: 12'(low - T_LO), sec: secure};
        end
        RG_ERREC: begin
          rt = '{act: ACT_FWD, tgt: TGT_ERREC, off: 12'(low), sec: secure};
        end
        RG_ASYS: begin
          if (secure) rt = '{act: ACT_FWD, tgt: TGT_SYS, off: 12'(low), sec: 1'b0};
          else        unclaimed = 1'b1;
        end
        RG_ATICK: begin
          if (secure) rt = '{act: ACT_FWD, tgt: TGT_TICK_NS, off: 12'(low - T_LO), sec: 1'b0};
          else        unclaimed = 1'b1;
        end
        default: unclaimed = 1'b1;
      endcase
      if (unclaimed) rt.act = user ? ACT_FAULT : ACT_RAZ;
    end
  end
endmodule

// File: rtl/ppb_rsp_sel.sv
module ppb_rsp_sel
  import ppb_pkg::*;
#(
  parameter int DW = 64
) (
  input  act_e                 act,
  input  logic [1:0]           idx,
  input  logic                 write,
  input  logic [NUM_TGT*DW-1:0] tgt_rdata,
  input  logic [NUM_TGT-1:0]   tgt_err,
  output logic [DW-1:0]        rdata,
  output logic                 err
);
  always_comb begin
    rdata = '0;
    err   = 1'b0;
    case (act)
      ACT_FWD: begin
        err = tgt_err[idx];
        if (!write && !err) rdata = tgt_rdata[idx*DW +: DW];
      end
      ACT_FAULT: err = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ppb_router.sv
module ppb_router
  import ppb_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 64,
  parameter int          WIN_AW    = 20,
  parameter int          PAGE_AW   = 12,
  parameter logic [31:0] WIN_BASE  = 32'hE000_0000,
  parameter int          SYS_PAGE  = 'h0E,
  parameter int          ALIAS_PG  = 'h2E,
  parameter int          EREC_PAGE = 'h05,
  parameter int          TICK_LO   = 'h010,
  parameter int          TICK_LEN  = 'h0E0,
  parameter bit          SEC_EN    = 1'b1,
  parameter bit          ERR_EN    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_addr,
  input  logic [3:0]            req_size,
  input  logic                  req_write,
  input  logic [DW-1:0]         req_wdata,
  input  logic                  req_secure,
  input  logic                  req_user,
  output logic [NUM_TGT-1:0]    tgt_valid,
  output logic [PAGE_AW-1:0]    tgt_addr,
  output logic [3:0]            tgt_size,
  output logic                  tgt_write,
  output logic [DW-1:0]         tgt_wdata,
  output logic                  tgt_secure,
  output logic                  tgt_user,
  input  logic [NUM_TGT*DW-1:0] tgt_rdata,
  input  logic [NUM_TGT-1:0]    tgt_err,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  rsp_err
);
  logic [NUM_RGN-1:0] hit;
  rgn_e               sel;
  logic               any;
  route_t             rt;
  logic [DW-1:0]      nxt_rdata;
  logic               nxt_err;

  ppb_region_hit #(
    .AW(AW), .WIN_AW(WIN_AW), .PAGE_AW(PAGE_AW), .WIN_BASE(WIN_BASE),
    .SYS_PAGE(SYS_PAGE), .ALIAS_PG(ALIAS_PG), .EREC_PAGE(EREC_PAGE),
    .TICK_LO(TICK_LO), .TICK_LEN(TICK_LEN), .SEC_EN(SEC_EN), .ERR_EN(ERR_EN)
  ) u_hit (
    .addr(req_addr),
    .hit (hit)
  );

  ppb_prio_pick #(.NR(NUM_RGN)) u_pick (
    .hit(hit),
    .sel(sel),
    .any(any)
  );

  ppb_route #(.PAGE_AW(PAGE_AW), .TICK_LO(TICK_LO), .SEC_EN(SEC_EN)) u_route (
    .any   (any),
    .sel   (sel),
    .size  (req_size),
    .secure(req_secure),
    .user  (req_user),
    .low   (req_addr[PAGE_AW-1:0]),
    .rt    (rt)
  );

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_strobe
    assign tgt_valid[k] = req_valid && (rt.act == ACT_FWD) && (rt.tgt == 2'(k));
  end

  assign tgt_addr   = PAGE_AW'(rt.off);
  assign tgt_size   = req_size;
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
  assign tgt_secure = rt.sec;
  assign tgt_user   = req_user;

  ppb_rsp_sel #(.DW(DW)) u_rsp (
    .act      (rt.act),
    .idx      (rt.tgt),
    .write    (req_write),
    .tgt_rdata(tgt_rdata),
    .tgt_err  (tgt_err),
    .rdata    (nxt_rdata),
    .err      (nxt_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? nxt_rdata : '0;
      rsp_err   <= req_valid && nxt_err;
    end
  end
endmodule

// File: rtl/ppb_router_chk.sv
module ppb_router_chk
  import ppb_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 64,
  parameter int          WIN_AW   = 20,
  parameter int          PAGE_AW  = 12,
  parameter logic [31:0] WIN_BASE = 32'hE000_0000,
  parameter int          ALIAS_PG = 'h2E
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [AW-1:0]       req_addr,
  input logic [3:0]          req_size,
  input logic                req_secure,
  input logic                req_user,
  input logic [NUM_TGT-1:0]  tgt_valid,
  input logic                tgt_secure,
  input logic [NUM_TGT-1:0]  tgt_err,
  input logic                rsp_valid,
  input logic [DW-1:0]       rsp_rdata,
  input logic                rsp_err
);
  localparam int PG_W = WIN_AW - PAGE_AW;
  logic out_win, bad_size, on_alias;
  assign out_win  = req_addr[AW-1:WIN_AW] != WIN_BASE[AW-1:WIN_AW];
  assign bad_size = (req_size == 4'd0) || (req_size > 4'd8);
  assign on_alias = req_addr[WIN_AW-1:PAGE_AW] == PG_W'(ALIAS_PG);

  p_one_port_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_valid) && (req_valid || tgt_valid == '0));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_fwd_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && tgt_valid != '0 && (tgt_valid & tgt_err) == '0) |=> !rsp_err);

  p_outside_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && out_win) |-> (tgt_valid == '0));

  p_outside_err_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && out_win) |=> (rsp_err && rsp_rdata == '0));

  p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_size) |=> rsp_err);

  p_user_unclaimed_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && tgt_valid == '0) |=> rsp_err);

  p_secure_tick_r6: assert property (@(posedge clk) disable iff (rst)
    tgt_valid[TGT_TICK_S] |-> (req_secure && tgt_secure));

  p_alias_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && on_alias && !out_win && tgt_valid != '0) |-> !tgt_secure);
endmodule

bind ppb_router ppb_router_chk #(
  .AW(AW), .DW(DW), .WIN_AW(WIN_AW), .PAGE_AW(PAGE_AW),
  .WIN_BASE(WIN_BASE), .ALIAS_PG(ALIAS_PG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_secure(req_secure),
  .req_user  (req_user),
  .tgt_valid (tgt_valid),
  .tgt_secure(tgt_secure),
  .tgt_err   (tgt_err),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/ppb_router_tb_top.sv
module ppb_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic [31:0]   req_addr  = '0;
  logic [3:0]    req_size  = 4'd4;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_secure = 1'b0;
  logic          req_user  = 1'b0;

  // Instance A: security extension and error-record block present.
  logic [NT-1:0]    a_tv;  logic [11:0] a_ta; logic [3:0] a_ts; logic a_tw;
  logic [DW-1:0]    a_twd; logic a_tsec; logic a_tu;
  logic [NT*DW-1:0] a_trd; logic [NT-1:0] a_terr;
  logic             a_rv;  logic [DW-1:0] a_rd; logic a_re;
  // Instance B: both features left out.
  logic [NT-1:0]    b_tv;  logic [11:0] b_ta; logic [3:0] b_ts; logic b_tw;
  logic [DW-1:0]    b_twd; logic b_tsec; logic b_tu;
  logic [NT*DW-1:0] b_trd; logic [NT-1:0] b_terr;
  logic             b_rv;  logic [DW-1:0] b_rd; logic b_re;

  function automatic logic [DW-1:0] tdata(int k, logic [11:0] off, logic sec);
    return {8'hA0 + 8'(k), 43'd0, sec, off};
  endfunction

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      a_trd[k*DW +: DW] = tdata(k, a_ta, a_tsec);
      b_trd[k*DW +: DW] = tdata(k, b_ta, b_tsec);
      a_terr[k] = (a_ta == 12'hFFC);
      b_terr[k] = (b_ta == 12'hFFC);
    end
  end

  ppb_router #(.SEC_EN(1'b1), .ERR_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user),
    .tgt_valid(a_tv), .tgt_addr(a_ta), .tgt_size(a_ts), .tgt_write(a_tw),
    .tgt_wdata(a_twd), .tgt_secure(a_tsec), .tgt_user(a_tu),
    .tgt_rdata(a_trd), .tgt_err(a_terr),
    .rsp_valid(a_rv), .rsp_rdata(a_rd), .rsp_err(a_re));

  ppb_router #(.SEC_EN(1'b0), .ERR_EN(1'b0)) dut_b_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user),
    .tgt_valid(b_tv), .tgt_addr(b_ta), .tgt_size(b_ts), .tgt_write(b_tw),
    .tgt_wdata(b_twd), .tgt_secure(b_tsec), .tgt_user(b_tu),
    .tgt_rdata(b_trd), .tgt_err(b_terr),
    .rsp_valid(b_rv), .rsp_rdata(b_rd), .rsp_err(b_re));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s addr=%h: actual=%h expected=%h", tag, what, req_addr, act, exp);
    end
  endtask

  // Bench reference: action 0 forward, 1 read-as-zero, 2 fault.
  typedef struct packed {
    logic [1:0]  act;
    logic [1:0]  tgt;
    logic [11:0] off;
    logic        fsec;
  } exp_t;

  function automatic exp_t model(logic [31:0] a, logic [3:0] sz, logic s, logic u, bit se, bit ee);
    exp_t e;
    logic [7:0]  pg = a[19:12];
    logic [11:0] lo = a[11:0];
    bit tk = (lo >= 12'h010) && (lo <= 12'h0EF);
    logic fs;
    e = '{act: 2'd2, tgt: 2'd0, off: 12'd0, fsec: 1'b0};
    if (a[31:20] != 12'hE00 || sz == 4'd0 || sz > 4'd8) return e;
    if (ee && pg == 8'h05) begin
      e.act = 2'd0; e.tgt = 2'd3; e.off = lo; e.fsec = s;
    end else if (pg == 8'h0E || (se && s && pg == 8'h2E)) begin
      fs = (pg == 8'h2E) ? 1'b0 : s;
      e.act = 2'd0; e.fsec = fs;
      if (tk) begin e.tgt = (se && fs) ? 2'd2 : 2'd1; e.off = lo - 12'h010; end
      else    begin e.tgt = 2'd0; e.off = lo; end
    end else begin
      e.act = u ? 2'd2 : 2'd1;
    end
    return e;
  endfunction

  function automatic string tag_of(logic [31:0] a, logic [3:0] sz, logic s, bit se, bit ee);
    logic [7:0]  pg = a[19:12];
    logic [11:0] lo = a[11:0];
    if (a[31:20] != 12'hE00) return "R1";
    if (sz == 4'd0 || sz > 4'd8) return "R2";
    if ((!se && pg == 8'h2E) || (!ee && pg == 8'h05)) return "R11";
    if (pg == 8'h05) return "R9";
    if (pg == 8'h0E) begin
      if (lo >= 12'h010 && lo <= 12'h0EF) return s ? "R6" : "R5";
      return "R4";
    end
    if (pg == 8'h2E) return s ? "R7" : "R8";
    return "R3";
  endfunction

  task automatic check_comb(bit se, bit ee, logic [NT-1:0] tv, logic [11:0] ta, logic tsec);
    exp_t e = model(req_addr, req_size, req_secure, req_user, se, ee);
    string t = tag_of(req_addr, req_size, req_secure, se, ee);
    logic [NT-1:0] ev = (e.act == 2'd0) ? (NT'(1) << e.tgt) : '0;
    check(tv == ev, t, "port strobe", DW'(tv), DW'(ev));
    if (e.act == 2'd0) begin
      check(ta == e.off, t, "target offset", DW'(ta), DW'(e.off));
      check(tsec == e.fsec, t, "target secure", DW'(tsec), DW'(e.fsec));
    end
  endtask

  task automatic check_rsp(bit se, bit ee, logic rv, logic [DW-1:0] rd, logic re,
                           logic [31:0] a, logic [3:0] sz, logic w, logic s, logic u);
    exp_t e = model(a, sz, s, u, se, ee);
    string t = tag_of(a, sz, s, se, ee);
    logic ee_err;
    logic [DW-1:0] ed;
    ee_err = (e.act == 2'd2) || (e.act == 2'd0 && e.off == 12'hFFC);
    ed = (e.act == 2'd0 && !w && !ee_err) ? tdata(int'(e.tgt), e.off, e.fsec) : '0;
    check(rv == 1'b1, "R10", "rsp_valid", DW'(rv), 64'd1);
    check(re == ee_err, t, "rsp_err", DW'(re), DW'(ee_err));
    check(rd == ed, t, "rsp_rdata", rd, ed);
  endtask

  task automatic txn(logic [31:0] a, logic [3:0] sz, logic w, logic s, logic u);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w;
    req_secure = s; req_user = u; req_wdata = {$urandom, $urandom};
    #1;
    check_comb(1'b1, 1'b1, a_tv, a_ta, a_tsec);
    check_comb(1'b0, 1'b0, b_tv, b_ta, b_tsec);
    @(negedge clk);
    check_rsp(1'b1, 1'b1, a_rv, a_rd, a_re, a, sz, w, s, u);
    check_rsp(1'b0, 1'b0, b_rv, b_rd, b_re, a, sz, w, s, u);
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    repeat (3) @(negedge clk);
    // Reset state.
    check(a_rv == 1'b0 && a_re == 1'b0 && a_rd == '0, "R10", "reset rsp", {a_rv, a_re}, 0);
    check(a_tv == '0, "R12", "reset strobe", DW'(a_tv), 0);
    rst = 1'b0;
    @(negedge clk);
    check(a_rv == 1'b0 && b_rv == 1'b0, "R10", "idle rsp_valid", DW'(a_rv), 0);

    // Directed corners.
    txn(32'hE000_E00C, 4'd4, 1'b0, 1'b0, 1'b0); // R4 just below tick slice
    txn(32'hE000_E010, 4'd4, 1'b0, 1'b0, 1'b0); // R5 first tick byte
    txn(32'hE000_E0EF, 4'd1, 1'b0, 1'b1, 1'b0); // R6 last tick byte, secure
    txn(32'hE000_E0F0, 4'd4, 1'b0, 1'b1, 1'b1); // R4 just above tick slice
    txn(32'hE000_EFFC, 4'd4, 1'b0, 1'b0, 1'b0); // R10 target error passthrough
    txn(32'hE000_E020, 4'd4, 1'b1, 1'b1, 1'b0); // R6 write, zero rdata
    txn(32'hE002_E018, 4'd4, 1'b0, 1'b1, 1'b0); // R7 secure alias tick
    txn(32'hE002_ED00, 4'd4, 1'b0, 1'b1, 1'b1); // R7 secure alias sys regs
    txn(32'hE002_ED00, 4'd4, 1'b0, 1'b0, 1'b0); // R8 NS privileged RAZ
    txn(32'hE002_ED00, 4'd4, 1'b1, 1'b0, 1'b1); // R8 NS user fault
    txn(32'hE000_5008, 4'd8, 1'b0, 1'b0, 1'b0); // R9 error record, 8 bytes
    txn(32'hE000_1000, 4'd4, 1'b1, 1'b0, 1'b0); // R3 privileged write ignored
    txn(32'hE000_1000, 4'd4, 1'b0, 1'b0, 1'b0); // R3 read back zero
    txn(32'hE000_1000, 4'd2, 1'b0, 1'b0, 1'b1); // R3 user fault
    txn(32'hE000_E100, 4'd0, 1'b0, 1'b0, 1'b0); // R2 size zero
    txn(32'hE000_E100, 4'd9, 1'b0, 1'b0, 1'b0); // R2 size nine
    txn(32'hE010_0000, 4'd4, 1'b0, 1'b0, 1'b0); // R1 just above window
    txn(32'hDFFF_FFFC, 4'd4, 1'b0, 1'b1, 1'b0); // R1 just below window

    // Constrained random mix.
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [7:0]  pg;
      logic [11:0] lo;
      case ($urandom % 8)
        0, 1:    pg = 8'h0E;
        2, 3:    pg = 8'h2E;
        4:       pg = 8'h05;
        default: pg = 8'($urandom);
      endcase
      lo = ($urandom % 2 == 0) ? 12'($urandom % 'h120) : 12'($urandom);
      a  = {(($urandom % 16) == 0) ? 12'($urandom) : 12'hE00, pg, lo};
      txn(a, 4'($urandom % 10), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    req_valid = 1'b0;
    #1;
    check(a_tv == '0 && b_tv == '0, "R12", "no strobe when idle", DW'(a_tv), 0);
    @(negedge clk);
    check(a_rv == 1'b0 && b_rv == 1'b0, "R10", "rsp_valid drops", DW'(a_rv), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule